// File: doc/BRIEF.md
# Power Button Long-Press Timer

This block turns a clean, already-debounced power-button level into two timed requests for the power controller. The first is a request to start the system. The second is a request to force the system off. Hold time is measured in whole ticks of a free-running millisecond strobe.

When a press begins while the system reports that it is in an off state, a short hold timer is armed and a boot request pulse follows once the hold is long enough. Every press also arms a long hold timer that ends in a forced-shutdown request. A configuration input selects the shorter of two shutdown hold times. Letting go of the button cancels whatever has not yet fired.

If the system drops into suspend while the button is still down, the shutdown request is raised at once instead of waiting for the timer. The block also holds a forcing-shutdown flag. A shutdown request sets it, and a button-initiated boot clears it.

Top module: `pbt_longpress_top`

## Requirements
- R1: A press that begins in a cycle with `all_off_i`=1 raises `boot_req_o` for one cycle, the cycle after the BOOT_MS-th tick counted while the button stays held. Ticks are counted from the cycle after the press edge.
- R2: A press that begins with `all_off_i`=0 never raises `boot_req_o`, however long the button is held.
- R3: Every press with `short_hold_i`=0 raises `shut_req_o` for one cycle, the cycle after the LONG_MS-th tick counted while the button is held.
- R4: With `short_hold_i`=1 the shutdown hold is SHORT_MS ticks instead of LONG_MS.
- R5: Releasing the button (`btn_i`=0) before a timer expires cancels both pending requests. The next press restarts both counts from zero.
- R6: A one-cycle `suspend_i` while the button is held and the shutdown request has not yet fired for this press raises `shut_req_o` in the next cycle.
- R7: Each request output is a single-cycle pulse and fires at most once per press. Holding past expiry does not fire it again.
- R8: `force_off_o` goes to 1 the cycle after a `shut_req_o` pulse and to 0 the cycle after a `boot_req_o` pulse. When both pulses occur in the same cycle, shutdown wins.
- R9: During and right after reset, `boot_req_o`, `shut_req_o` and `force_off_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_i | input | 1 | Debounced button level, 1 = pressed |
| all_off_i | input | 1 | 1 while the system is in any off state |
| tick_i | input | 1 | One-cycle millisecond strobe |
| suspend_i | input | 1 | One-cycle event: system went from running to suspend |
| short_hold_i | input | 1 | 1 selects SHORT_MS as the shutdown hold time |
| boot_req_o | output | 1 | Boot request pulse |
| shut_req_o | output | 1 | Forced-shutdown request pulse |
| force_off_o | output | 1 | Forcing-shutdown flag |

## Verification
The main function is exercised with holds that stop one tick short of each threshold, land exactly on it, and run well past it. This separates an off-by-one in the counters from a re-fire after saturation. Presses that start in the off and on states show whether boot arming is sampled at the press edge. Both shutdown hold settings are tried. Suspend events arrive early in a hold, including one that comes before the boot threshold and is then followed by release, which shows that the immediate shutdown neither depends on the timer nor re-arms it. A release followed by a fresh partial press shows that the counts restart, and alternating shutdown and boot outcomes drive the forcing flag both ways.

// File: rtl/pbt_pkg.sv
package pbt_pkg;
    localparam int NUM_TMR  = 2;
    localparam int BOOT_IDX = 0;
    localparam int SHUT_IDX = 1;
endpackage

// File: rtl/pbt_press_detect.sv
module pbt_press_detect (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic btn_i,
    output logic press_o
);
    logic btn_d, btn_q;

    always_comb begin
        btn_d   = btn_i;
        press_o = btn_i & ~btn_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) btn_q <= 1'b0;
        else         btn_q <= btn_d;
    end
endmodule

// File: rtl/pbt_hold_timer.sv
module pbt_hold_timer #(
    parameter int CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          held_i,
    input  logic          start_i,
    input  logic          arm_en_i,
    input  logic          tick_i,
    input  logic          force_i,
    input  logic [CW-1:0] limit_i,
    output logic          fire_o
);
    typedef struct packed {
        logic          armed;
        logic          fired;
        logic          fire;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.fire = 1'b0;
        if (!held_i) begin
            s_d.armed = 1'b0;
            s_d.fired = 1'b0;
            s_d.cnt   = '0;
        end else if (start_i) begin
            s_d.armed = arm_en_i;
            s_d.fired = 1'b0;
            s_d.cnt   = '0;
        end else if (s_q.armed && !s_q.fired) begin
            if (force_i) begin
                s_d.fire  = 1'b1;
                s_d.fired = 1'b1;
            end else if (tick_i) begin
                s_d.cnt = s_q.cnt + CW'(1);
                if ((s_q.cnt + CW'(1)) >= limit_i) begin
                    s_d.fire  = 1'b1;
                    s_d.fired = 1'b1;
                    s_d.cnt   = limit_i;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign fire_o = s_q.fire;

    // R7
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_o |=> !fire_o);

    // R5
    cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !held_i |=> !fire_o);

    // R6
    force_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (force_i && held_i && !start_i && s_q.armed && !s_q.fired) |=> fire_o);

    // R7
    no_refire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.fired && held_i && !start_i) |=> !fire_o);
endmodule

// File: rtl/pbt_longpress_top.sv
module pbt_longpress_top #(
    parameter int BOOT_MS  = 1000,
    parameter int LONG_MS  = 10000,
    parameter int SHORT_MS = 8000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic btn_i,
    input  logic all_off_i,
    input  logic tick_i,
    input  logic suspend_i,
    input  logic short_hold_i,
    output logic boot_req_o,
    output logic shut_req_o,
    output logic force_off_o
);
    import pbt_pkg::*;

    localparam int MAXA = (LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS;
    localparam int MAXL = (MAXA > BOOT_MS) ? MAXA : BOOT_MS;
    localparam int CW   = $clog2(MAXL + 1);

    logic          press;
    logic [CW-1:0] limit  [NUM_TMR];
    logic          arm_en [NUM_TMR];
    logic          frc    [NUM_TMR];
    logic [NUM_TMR-1:0] fire;
    logic          force_d, force_q;

    pbt_press_detect u_press (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .btn_i  (btn_i),
        .press_o(press)
    );

    always_comb begin
        limit[BOOT_IDX]  = CW'(BOOT_MS);
        limit[SHUT_IDX]  = short_hold_i ? CW'(SHORT_MS) : CW'(LONG_MS);
        arm_en[BOOT_IDX] = all_off_i;
        arm_en[SHUT_IDX] = 1'b1;
        frc[BOOT_IDX]    = 1'b0;
        frc[SHUT_IDX]    = suspend_i;
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        pbt_hold_timer #(.CW(CW)) u_tmr (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .held_i  (btn_i),
            .start_i (press),
            .arm_en_i(arm_en[g]),
            .tick_i  (tick_i),
            .force_i (frc[g]),
            .limit_i (limit[g]),
            .fire_o  (fire[g])
        );
    end

    assign boot_req_o = fire[BOOT_IDX];
    assign shut_req_o = fire[SHUT_IDX];

    always_comb begin
        force_d = force_q;
        if (shut_req_o)      force_d = 1'b1;
        else if (boot_req_o) force_d = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) force_q <= 1'b0;
        else         force_q <= force_d;
    end

    assign force_off_o = force_q;

    // R8
    force_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shut_req_o |=> force_off_o);

    // R8
    force_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (boot_req_o && !shut_req_o) |=> !force_off_o);
endmodule

// File: tb/sim_pbt_longpress_top.sv
module sim_pbt_longpress_top;
    localparam int BOOT = 4;
    localparam int LONG = 20;
    localparam int SHRT = 12;
    localparam int NV   = 12;

    // vector columns: all_off, short_hold, suspend-after-tick (0 = none), hold ticks, exp boot, exp shut
    localparam int VOFF [NV] = '{1, 0, 1, 0, 0, 1, 0, 0, 0, 1, 0, 1};
    localparam int VSH  [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0};
    localparam int VSUS [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 3, 1, 2, 0};
    localparam int VHLD [NV] = '{3, 20, 4, 4, 19, 30, 11, 12, 5, 2, 25, 4};
    localparam int VEB  [NV] = '{0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 1};
    localparam int VES  [NV] = '{0, 1, 0, 0, 0, 1, 0, 1, 1, 1, 1, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn = 1'b0, all_off = 1'b0, tick = 1'b0, susp = 1'b0, shorth = 1'b0;
    logic boot_req, shut_req, force_off;
    int   nboot = 0, nshut = 0;
    int   checks = 0, fails = 0;
    int   exp_force = 0;

    always #2.5 clk = ~clk;

    pbt_longpress_top #(.BOOT_MS(BOOT), .LONG_MS(LONG), .SHORT_MS(SHRT)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .btn_i(btn), .all_off_i(all_off),
        .tick_i(tick), .suspend_i(susp), .short_hold_i(shorth),
        .boot_req_o(boot_req), .shut_req_o(shut_req), .force_off_o(force_off)
    );

    always @(negedge clk) begin
        if (boot_req) nboot <= nboot + 1;
        if (shut_req) nshut <= nshut + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input int i);
        int b0, s0;
        all_off = VOFF[i][0];
        shorth  = VSH[i][0];
        @(negedge clk);
        b0 = nboot; s0 = nshut;
        btn = 1'b1;
        @(negedge clk);
        for (int t = 1; t <= VHLD[i]; t++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
            if (t == VSUS[i]) begin
                susp = 1'b1;
                @(negedge clk);
                susp = 1'b0;
                @(negedge clk);
            end
        end
        btn = 1'b0;
        repeat (3) @(negedge clk);
        if (VES[i] != 0)      exp_force = 1;
        else if (VEB[i] != 0) exp_force = 0;
        // R1 R2 boot outcome, R3 R4 R6 shutdown outcome, R7 at most one each, R8 flag
        check($sformatf("R1/R2 vec%0d boot", i), nboot - b0, VEB[i]);
        check($sformatf("R3/R4/R6/R7 vec%0d shut", i), nshut - s0, VES[i]);
        check($sformatf("R8 vec%0d force", i), int'(force_off), exp_force);
    endtask

    task automatic run_all();
        int b0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 boot during reset", int'(boot_req), 0);
        check("R9 shut during reset", int'(shut_req), 0);
        check("R9 force during reset", int'(force_off), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 force after reset", int'(force_off), 0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R5: partial hold, release, new press restarts from zero
        all_off = 1'b1; shorth = 1'b0;
        b0 = nboot;
        btn = 1'b1; @(negedge clk);
        for (int t = 0; t < BOOT - 1; t++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
        end
        btn = 1'b0; repeat (2) @(negedge clk);
        btn = 1'b1; @(negedge clk);
        for (int t = 0; t < BOOT - 1; t++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
        end
        check("R5 restart no early boot", nboot - b0, 0);
        // R1 exact cycle: pulse right after the BOOT-th tick
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        check("R1 boot pulse on expiry cycle", int'(boot_req), 1);
        @(negedge clk);
        check("R7 boot pulse one cycle", int'(boot_req), 0);
        // R5: ticks with button released are ignored
        btn = 1'b0; all_off = 1'b0; @(negedge clk);
        b0 = nshut;
        for (int t = 0; t < LONG + 2; t++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
        end
        check("R5 no request while released", nshut - b0, 0);
        // R6: suspend with button released has no effect
        susp = 1'b1; @(negedge clk); susp = 1'b0; repeat (2) @(negedge clk);
        check("R6 suspend ignored when released", nshut - b0, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule